// File: doc/BRIEF.md
# Fair D-Channel Access Arbiter

This block decides which subscriber D-channel may use a single shared HDLC receiver. Once per time-multiplexed frame it receives one D-bit sample for each channel. While it is selecting, a low bit on any channel it monitors counts as the start of a frame. The arbiter then grants the lowest-numbered requesting channel, latches that channel's address and raises the receive strobe toward the receiver.

After the grant, a byte-driven suspend counter limits how long the arbiter waits for the receiver to recognise a frame. If recognition does not arrive in time, the arbiter abandons the grant. When a frame completes, the served channel is struck from a served mask. Until the line has been quiet for a programmed number of frames, only channels that are both enabled and not yet served can win. Subscribers that request at almost the same moment are therefore each served once before any of them is served again.

Top module: `dca_arbiter`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `status` reads 0 (state code 000 = full selection, address 0) and `rx_strobe` is low.
- R2: In full selection, a cycle with `d_valid` high and a 0 in `d_bits` on any channel whose `chan_enable` bit is 1 moves the state to expect frame (code 001) on the next cycle and raises `rx_strobe`. A 0 on a disabled channel causes no grant.
- R3: When several monitored channels show 0 in the same sample, the lowest channel index is granted. `sel_addr` is the channel index, with the port number in the upper PORT_W bits and the slot number in the lower SLOT_W bits.
- R4: A grant loads the suspend counter with `suspend_reload`. Each `rx_byte` in expect frame decrements the counter. An `rx_byte` that arrives while the counter is 0, with no `rx_frame_ok` in the same cycle, drops `rx_strobe` and returns the state to full selection on the next cycle. With a reload value of k, byte k+1 causes this timeout.
- R5: `rx_frame_ok` in expect frame moves the state to receive frame (code 010) on the next cycle with `rx_strobe` still high. It takes priority over an `rx_byte` in the same cycle.
- R6: `rx_eof` in receive frame lowers `rx_strobe` on the next cycle and clears the served bit of the granted channel. If `idle_frames` is nonzero, the state becomes limited selection (code 100).
- R7: In limited selection, only a channel that is enabled AND not served since the last full selection can be granted. A change to `chan_enable` takes effect in the very sample it accompanies.
- R8: In limited selection, `idle_frames` (n) `frame_sync` ticks without a grant return the state to full selection on the cycle after the n-th tick. Every enabled channel is then eligible again.
- R9: When `idle_frames` is 0, `rx_eof` returns the state directly to full selection and limited selection is skipped.
- R10: `status[7:5]` holds the state code (000, 001, 010 or 100, never any other value). `status[4:0]` holds `sel_addr`, zero-extended. `sel_addr` keeps its value until the next grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | One-cycle tick once per multiplexed frame |
| d_valid | input | 1 | Qualifies the D-bit sample vector |
| d_bits | input | NUM_CH | One D-bit per channel, 0 = start of frame |
| chan_enable | input | NUM_CH | User enable mask, 1 = channel may be granted |
| suspend_reload | input | SUS_W | Byte budget loaded on each grant |
| idle_frames | input | IDLE_W | Quiet frames before full selection returns; 0 skips limited selection |
| rx_frame_ok | input | 1 | Receiver has recognised a frame |
| rx_byte | input | 1 | Receiver has taken one byte |
| rx_eof | input | 1 | Receiver has seen the end of the frame |
| rx_strobe | output | 1 | Receive enable toward the shared receiver |
| sel_addr | output | ADDR_W | Port and slot of the granted channel |
| status | output | 8 | State code in [7:5], address in [4:0] |

## Verification
A corrupt served mask shows up at the next request after a completed frame. The wrong channel wins in limited selection, which is visible on `sel_addr` one cycle after the sample. A suspend counter that is off by one moves the return of `status[7:5]` to 000 by exactly one byte. An idle-frame count error shifts the return to full selection by one `frame_sync` tick. The bench runs a behavioural model alongside the design and compares `status` and `rx_strobe` every cycle, so each of these faults is flagged within the cycle it first becomes visible.

// File: rtl/dca_pkg.sv
package dca_pkg;

    // State codes: one-hot, with the all-zero code reserved for full selection
    typedef enum logic [2:0] {
        ST_FULL   = 3'b000,
        ST_EXPECT = 3'b001,
        ST_RECV   = 3'b010,
        ST_LIMIT  = 3'b100
    } arb_state_t;

    localparam int STATUS_W = 8;
    localparam int ADDR_FIELD_W = 5;

    typedef struct packed {
        logic load;
        logic dec;
    } sus_ctl_t;

    function automatic logic [STATUS_W-1:0] pack_status(arb_state_t st,
                                                        logic [ADDR_FIELD_W-1:0] addr);
        return {st, addr};
    endfunction

endpackage

// File: rtl/dca_chan_select.sv
module dca_chan_select #(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 3
) (
    input  logic              valid,
    input  logic [NUM_CH-1:0] req_n,
    input  logic [NUM_CH-1:0] mask,
    output logic              hit,
    output logic [ADDR_W-1:0] idx
);
    // Scan from the top down so that the lowest requesting index is the one kept
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (valid && mask[i] && !req_n[i]) begin
                hit = 1'b1;
                idx = ADDR_W'(i);
            end
        end
    end
endmodule

// File: rtl/dca_suspend_cnt.sv
module dca_suspend_cnt
    import dca_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  sus_ctl_t     ctl,
    input  logic [W-1:0] reload,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (ctl.load)
            cnt_q <= reload;
        else if (ctl.dec && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // Decrementing past zero must never wrap to the top value
    assert_no_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (ctl.dec && !ctl.load && zero) |=> zero);
endmodule

// File: rtl/dca_idle_cnt.sv
module dca_idle_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         expire
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expire = tick && (({1'b0, cnt_q} + (W+1)'(1)) == {1'b0, limit});
endmodule

// File: rtl/dca_arbiter.sv
module dca_arbiter
    import dca_pkg::*;
#(
    parameter int PORT_W = 1,
    parameter int SLOT_W = 2,
    parameter int SUS_W  = 8,
    parameter int IDLE_W = 4,
    localparam int ADDR_W = PORT_W + SLOT_W,
    localparam int NUM_CH = 1 << ADDR_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_sync,
    input  logic                d_valid,
    input  logic [NUM_CH-1:0]   d_bits,
    input  logic [NUM_CH-1:0]   chan_enable,
    input  logic [SUS_W-1:0]    suspend_reload,
    input  logic [IDLE_W-1:0]   idle_frames,
    input  logic                rx_frame_ok,
    input  logic                rx_byte,
    input  logic                rx_eof,
    output logic                rx_strobe,
    output logic [ADDR_W-1:0]   sel_addr,
    output logic [STATUS_W-1:0] status
);
    arb_state_t        state_q, state_d;
    logic [NUM_CH-1:0] served_q;
    logic [NUM_CH-1:0] mon_mask;
    logic              selecting;
    logic              grant;
    logic [ADDR_W-1:0] grant_idx;
    logic              sus_zero;
    logic              underflow;
    logic              idle_expire;
    sus_ctl_t          sus_ctl;

    assign selecting = (state_q == ST_FULL) || (state_q == ST_LIMIT);
    assign mon_mask  = chan_enable & ((state_q == ST_LIMIT) ? served_q : '1);

    dca_chan_select #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_sel (
        .valid (d_valid && selecting),
        .req_n (d_bits),
        .mask  (mon_mask),
        .hit   (grant),
        .idx   (grant_idx)
    );

    assign sus_ctl.load = grant;
    assign sus_ctl.dec  = (state_q == ST_EXPECT) && rx_byte && !rx_frame_ok;

    dca_suspend_cnt #(.W(SUS_W)) u_sus (
        .clk    (clk),
        .rst    (rst),
        .ctl    (sus_ctl),
        .reload (suspend_reload),
        .zero   (sus_zero)
    );

    assign underflow = sus_ctl.dec && sus_zero;

    dca_idle_cnt #(.W(IDLE_W)) u_idle (
        .clk    (clk),
        .rst    (rst),
        .clr    (state_q != ST_LIMIT),
        .tick   ((state_q == ST_LIMIT) && frame_sync && !grant),
        .limit  (idle_frames),
        .expire (idle_expire)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FULL:   if (grant) state_d = ST_EXPECT;
            ST_EXPECT: begin
                if (rx_frame_ok)    state_d = ST_RECV;
                else if (underflow) state_d = ST_FULL;
            end
            ST_RECV:   if (rx_eof) state_d = (idle_frames == '0) ? ST_FULL : ST_LIMIT;
            ST_LIMIT: begin
                if (grant)            state_d = ST_EXPECT;
                else if (idle_expire) state_d = ST_FULL;
            end
            default:   state_d = ST_FULL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_FULL;
            sel_addr <= '0;
            served_q <= '1;
        end else begin
            state_q <= state_d;
            if (grant)
                sel_addr <= grant_idx;
            if (state_d == ST_FULL)
                served_q <= '1;
            else if (state_q == ST_RECV && rx_eof)
                served_q[sel_addr] <= 1'b0;
        end
    end

    assign rx_strobe = (state_q == ST_EXPECT) || (state_q == ST_RECV);
    assign status    = pack_status(state_q, ADDR_FIELD_W'(sel_addr));

    // Guards
    assert_state_code_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(state_q));

    assert_strobe_from_sample_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_strobe) |-> $past(d_valid));

    assert_addr_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (rx_strobe && $past(rx_strobe)) |-> $stable(sel_addr));

    assert_timeout_exit_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXPECT && rx_byte && !rx_frame_ok && sus_zero) |=> (state_q == ST_FULL));

    assert_eof_drops_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RECV && rx_eof) |=> !rx_strobe);

    assert_limited_pick_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LIMIT && grant) |-> (served_q[grant_idx] && chan_enable[grant_idx]));

    assert_pick_requested_R3: assert property (@(posedge clk) disable iff (rst)
        grant |-> !d_bits[grant_idx]);
endmodule

// File: tb/sim_dca_arbiter.sv
`timescale 1ns/1ps
module sim_dca_arbiter;
    localparam int NCH = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           frame_sync = 1'b0;
    logic           d_valid = 1'b0;
    logic [NCH-1:0] d_bits = '1;
    logic [NCH-1:0] chan_enable = '1;
    logic [7:0]     suspend_reload = 8'd3;
    logic [3:0]     idle_frames = 4'd2;
    logic           rx_frame_ok = 1'b0;
    logic           rx_byte = 1'b0;
    logic           rx_eof = 1'b0;
    logic           rx_strobe;
    logic [2:0]     sel_addr;
    logic [7:0]     status;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dca_arbiter u0 (
        .clk(clk), .rst(rst), .frame_sync(frame_sync), .d_valid(d_valid),
        .d_bits(d_bits), .chan_enable(chan_enable), .suspend_reload(suspend_reload),
        .idle_frames(idle_frames), .rx_frame_ok(rx_frame_ok), .rx_byte(rx_byte),
        .rx_eof(rx_eof), .rx_strobe(rx_strobe), .sel_addr(sel_addr), .status(status)
    );

    // Behavioural reference: 0 full, 1 expect, 2 receive, 4 limited
    int       m_state = 0;
    int       m_addr = 0;
    int       m_cnt = 0;
    int       m_idle = 0;
    bit [7:0] m_served = 8'hFF;

    always @(posedge clk) begin
        if (rst) begin
            m_state = 0; m_addr = 0; m_cnt = 0; m_idle = 0; m_served = 8'hFF;
        end else begin
            case (m_state)
                0, 4: begin
                    bit [7:0] req;
                    int pick;
                    req  = ~d_bits & chan_enable & ((m_state == 4) ? m_served : 8'hFF);
                    pick = -1;
                    if (d_valid)
                        for (int i = 0; i < NCH; i++)
                            if (req[i] && pick < 0) pick = i;
                    if (pick >= 0) begin
                        m_addr = pick; m_cnt = suspend_reload; m_state = 1;
                    end else if (m_state == 4 && frame_sync) begin
                        m_idle++;
                        if (m_idle == idle_frames) begin m_state = 0; m_served = 8'hFF; end
                    end
                end
                1: begin
                    if (rx_frame_ok) m_state = 2;
                    else if (rx_byte) begin
                        if (m_cnt == 0) begin m_state = 0; m_served = 8'hFF; end
                        else m_cnt--;
                    end
                end
                2: begin
                    if (rx_eof) begin
                        m_served[m_addr] = 1'b0;
                        if (idle_frames == 0) begin m_state = 0; m_served = 8'hFF; end
                        else begin m_state = 4; m_idle = 0; end
                    end
                end
                default: m_state = 0;
            endcase
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (status !== {3'(m_state), 2'b00, 3'(m_addr)}) begin
                errors++;
                $display("FAIL R10 status per-cycle: actual %h expected %h", status,
                         {3'(m_state), 2'b00, 3'(m_addr)});
            end
            checks++;
            if (rx_strobe !== (m_state == 1 || m_state == 2)) begin
                errors++;
                $display("FAIL R2 strobe per-cycle: actual %b expected %b", rx_strobe,
                         (m_state == 1 || m_state == 2));
            end
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic sample(input logic [7:0] lows);
        d_bits = ~lows; d_valid = 1'b1;
        step();
        d_bits = '1; d_valid = 1'b0;
    endtask

    task automatic pulse_ok();  rx_frame_ok = 1'b1; step(); rx_frame_ok = 1'b0; endtask
    task automatic pulse_eof(); rx_eof = 1'b1; step(); rx_eof = 1'b0; endtask
    task automatic pulse_byte(); rx_byte = 1'b1; step(); rx_byte = 1'b0; endtask
    task automatic pulse_sync(); frame_sync = 1'b1; step(); frame_sync = 1'b0; endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        step(); step();
        chk("R1 status in reset", status, 8'h00);
        chk("R1 strobe in reset", {7'b0, rx_strobe}, 8'h00);
        rst = 1'b0;
        step();
        chk("R1 status after reset", status, 8'h00);

        // Two channels low at once: lowest wins
        sample(8'h24);
        chk("R3 lowest of ch2/ch5", status, 8'h22);
        chk("R2 strobe on grant", {7'b0, rx_strobe}, 8'h01);

        pulse_byte(); pulse_byte();
        chk("R4 bytes within budget", status, 8'h22);
        rx_byte = 1'b1; pulse_ok(); rx_byte = 1'b0;
        chk("R5 frame recognised", status, 8'h42);

        pulse_eof();
        chk("R6 limited after eof", status, 8'h82);
        chk("R6 strobe low", {7'b0, rx_strobe}, 8'h00);

        // ch2 is served now, so ch5 wins
        sample(8'h24);
        chk("R7 served ch2 skipped", status, 8'h25);
        pulse_ok(); pulse_eof();
        chk("R6 limited again", status, 8'h85);

        // ch2, ch5 served, ch6 disabled in the same sample
        chan_enable = 8'hBF;
        sample(8'h64);
        chan_enable = 8'hFF;
        chk("R7 no eligible channel", status, 8'h85);

        pulse_sync();
        chk("R8 one idle frame", status, 8'h85);
        pulse_sync();
        chk("R8 back to full", status, 8'h05);

        sample(8'h04);
        chk("R8 ch2 eligible again", status, 8'h22);

        // Suspend timeout with reload 3
        pulse_byte(); pulse_byte(); pulse_byte();
        chk("R4 third byte still waiting", status, 8'h22);
        pulse_byte();
        chk("R4 timeout to full", status, 8'h02);
        chk("R4 strobe dropped", {7'b0, rx_strobe}, 8'h00);

        // Disabled channel in full selection
        chan_enable = 8'h0F;
        sample(8'h80);
        chan_enable = 8'hFF;
        chk("R2 disabled ignored", status, 8'h02);

        // n = 0 skips limited selection
        idle_frames = 4'd0;
        sample(8'h08);
        chk("R2 grant ch3", status, 8'h23);
        pulse_ok(); pulse_eof();
        chk("R9 eof to full", status, 8'h03);

        // Highest address reaches status
        sample(8'h80);
        chk("R10 address 7", status, 8'h27);
        chk("R10 sel_addr", {5'b0, sel_addr}, 8'h07);

        step();
        finish_run();
    end
endmodule